// File: doc/BRIEF.md
# Serial EEPROM Command Front End with Clock-Count Write Guard

This block receives commands for a three-wire serial EEPROM in byte-wide organization and owns a small byte array behind them. While chip select is high it watches the serial clock. It waits for a start bit, then collects the op-code, the address and, for some commands, a data byte. From the start bit until chip select drops, it counts every serial clock pulse.

A noise pulse on the serial clock moves every later bit one place along, so a damaged frame would name the wrong address and carry the wrong data. To prevent this, a command that modifies memory is carried out only when the pulse count equals the exact length that its op-code calls for. Any other count discards the command and leaves the array unchanged.

The serial inputs are sampled with the system clock. Edges are found from registered copies of the inputs. A short read command returns the addressed byte on a valid/ready output. The byte stays on the output until a consumer accepts it. While one byte is waiting, further read commands are dropped.

Top module: `mw_guard_top`

## Requirements
- R1: After reset every byte of the array reads 0x00, rd_valid is low and the write-enable latch is cleared.
- R2: Serial data is sampled on rising serial-clock edges while chip select is high. The first 1 sampled is the start bit. Zeros before it are neither counted nor decoded. Serial-clock pulses while chip select is low have no effect.
- R3: The WRITE command is start bit, op-code 01, 9 address bits MSB first, then 8 data bits MSB first, for a total of 20 clocks. It stores the data byte at the address.
- R4: A modifying command whose pulse count at the fall of chip select differs from its expected length is discarded. This covers one extra pulse (21 clocks for WRITE) and one missing pulse (19), and no byte changes.
- R5: A valid command takes effect on the system-clock cycle that follows the cycle in which chip select is first seen low.
- R6: With op-code 00, the address MSBs 11 (enable) or 00 (disable) set or clear the write-enable latch in a 12-clock frame. While the latch is clear, WRITE, ERASE, fill-erase and fill-write change nothing.
- R7: ERASE is op-code 11 plus 9 address bits (12 clocks) and writes 0xFF to the addressed byte. A 13-clock ERASE is discarded.
- R8: Op-code 00 with address MSBs 10 in 12 clocks writes 0xFF to every byte. Op-code 00 with MSBs 01 plus a data byte in 20 clocks writes that byte to every location.
- R9: READ is op-code 10 plus 9 address bits (12 clocks). It loads rd_data and raises rd_valid. Both hold steady until rd_ready is high at a clock edge. A READ that arrives while rd_valid is high is dropped.
- R10: The pulse counter saturates at 63 (default sizes), so a frame that is far too long can never wrap around to a valid length. A WRITE frame with 64 extra pulses is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high; its fall ends a frame |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data, sampled on serial-clock rising edges |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer accepts the read byte |
| rd_data | output | 8 | Byte returned by the last accepted READ |

## Verification
The assertions assume that cs, sclk and sdi are synchronous to clk. They also assume that each serial-clock level lasts at least two system clocks, that sdi is stable across the rising serial-clock edge, and that chip select changes only while sclk is low. Under these conditions a registered-copy edge detector sees every pulse exactly once. The bench meets these conditions by changing its inputs only on falling system-clock edges and holding every serial-clock phase for two cycles. It also raises and lowers chip select only while sclk is low. rd_ready is the only input the assertions place no limit on.

// File: rtl/mw_guard_pkg.sv
package mw_guard_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_WRITE,
    ACT_ERASE,
    ACT_FILL_ERASE,
    ACT_FILL_WRITE,
    ACT_READ,
    ACT_WEN_SET,
    ACT_WEN_CLR
  } mw_act_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] SUB_WEN_CLR    = 2'b00;
  localparam logic [1:0] SUB_FILL_WRITE = 2'b01;
  localparam logic [1:0] SUB_FILL_ERASE = 2'b10;
  localparam logic [1:0] SUB_WEN_SET    = 2'b11;

  // start bit + two op-code bits + address
  function automatic int short_frame_len(input int aw);
    return 3 + aw;
  endfunction

  function automatic int long_frame_len(input int aw, input int dw);
    return 3 + aw + dw;
  endfunction

  // wide enough that saturation sits well above the longest legal frame
  function automatic int count_width(input int aw, input int dw);
    return $clog2(3 + aw + dw + 2) + 1;
  endfunction
endpackage

// File: rtl/mw_frame_rx.sv
module mw_frame_rx #(
  parameter int AW = 9,
  parameter int DW = 8,
  parameter int CW = mw_guard_pkg::count_width(AW, DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             sclk,
  input  logic             sdi,
  output logic             fr_vld,
  output logic [CW-1:0]    fr_cnt,
  output logic [3:0]       fr_head,
  output logic [AW+DW-1:0] fr_body,
  output logic             active_o
);
  localparam int BW = AW + DW;
  localparam logic [CW-1:0] CNT_MAX  = '1;
  localparam logic [CW-1:0] HEAD_END = CW'(4);

  logic          sclk_q, cs_q, active;
  logic [CW-1:0] cnt;
  logic [3:0]    head;
  logic [BW-1:0] body;
  logic          rise, fall;

  assign rise     = sclk & ~sclk_q & cs;
  assign fall     = cs_q & ~cs;
  assign active_o = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b0;
      active  <= 1'b0;
      cnt     <= '0;
      head    <= '0;
      body    <= '0;
      fr_vld  <= 1'b0;
      fr_cnt  <= '0;
      fr_head <= '0;
      fr_body <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs;
      fr_vld <= 1'b0;
      if (fall) begin
        // hand the finished frame to the decoder, then rearm
        fr_vld  <= active;
        fr_cnt  <= cnt;
        fr_head <= head;
        fr_body <= body;
        active  <= 1'b0;
        cnt     <= '0;
        head    <= '0;
        body    <= '0;
      end else if (!cs) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (rise) begin
        if (!active) begin
          if (sdi) begin
            active <= 1'b1;
            cnt    <= CW'(1);
          end
        end else begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          // op-code and the two address MSBs arrive at pulses 2..5
          if (cnt <= HEAD_END) head <= {head[2:0], sdi};
          body <= {body[BW-2:0], sdi};
        end
      end
    end
  end
endmodule

// File: rtl/mw_cmd_decode.sv
module mw_cmd_decode
  import mw_guard_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 8,
  parameter int CW = count_width(AW, DW)
) (
  input  logic             fr_vld,
  input  logic [CW-1:0]    fr_cnt,
  input  logic [3:0]       fr_head,
  input  logic [AW+DW-1:0] fr_body,
  output mw_act_e          act,
  output logic [AW-1:0]    addr,
  output logic [DW-1:0]    data
);
  localparam logic [CW-1:0] LEN_SHORT = CW'(short_frame_len(AW));
  localparam logic [CW-1:0] LEN_LONG  = CW'(long_frame_len(AW, DW));

  logic [1:0]    opc, sub;
  logic [CW-1:0] want;
  mw_act_e       kind;

  assign opc = fr_head[3:2];
  assign sub = fr_head[1:0];

  always_comb begin
    kind = ACT_NONE;
    want = LEN_SHORT;
    unique case (opc)
      OPC_WRITE: begin kind = ACT_WRITE; want = LEN_LONG;  end
      OPC_READ:  begin kind = ACT_READ;  want = LEN_SHORT; end
      OPC_ERASE: begin kind = ACT_ERASE; want = LEN_SHORT; end
      OPC_EXT: begin
        unique case (sub)
          SUB_WEN_CLR:    begin kind = ACT_WEN_CLR;    want = LEN_SHORT; end
          SUB_WEN_SET:    begin kind = ACT_WEN_SET;    want = LEN_SHORT; end
          SUB_FILL_ERASE: begin kind = ACT_FILL_ERASE; want = LEN_SHORT; end
          SUB_FILL_WRITE: begin kind = ACT_FILL_WRITE; want = LEN_LONG;  end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  // only an exact pulse count keeps the fields aligned
  assign act = (fr_vld && fr_cnt == want) ? kind : ACT_NONE;

  always_comb begin
    if (want == LEN_LONG) begin
      addr = fr_body[AW+DW-1:DW];
      data = fr_body[DW-1:0];
    end else begin
      addr = fr_body[AW-1:0];
      data = '1;
    end
  end
endmodule

// File: rtl/mw_byte_array.sv
module mw_byte_array #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_one,
  input  logic          we_all,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we_all || (we_one && waddr == AW'(i))) mem[i] <= wdata;
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mw_guard_top.sv
module mw_guard_top
  import mw_guard_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sclk,
  input  logic          sdi,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = count_width(AW, DW);

  logic             fr_vld, rx_active;
  logic [CW-1:0]    fr_cnt;
  logic [3:0]       fr_head;
  logic [AW+DW-1:0] fr_body;
  mw_act_e          act;
  logic [AW-1:0]    cmd_addr;
  logic [DW-1:0]    cmd_data, mem_q;
  logic             wen, we_one, we_all, mem_we, rd_load;

  mw_frame_rx #(.AW(AW), .DW(DW), .CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
    .fr_vld(fr_vld), .fr_cnt(fr_cnt), .fr_head(fr_head),
    .fr_body(fr_body), .active_o(rx_active)
  );

  mw_cmd_decode #(.AW(AW), .DW(DW), .CW(CW)) u_dec (
    .fr_vld(fr_vld), .fr_cnt(fr_cnt), .fr_head(fr_head),
    .fr_body(fr_body), .act(act), .addr(cmd_addr), .data(cmd_data)
  );

  assign we_one = wen && (act == ACT_WRITE || act == ACT_ERASE);
  assign we_all = wen && (act == ACT_FILL_WRITE || act == ACT_FILL_ERASE);
  assign mem_we = we_one | we_all;

  mw_byte_array #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we_one(we_one), .we_all(we_all),
    .waddr(cmd_addr), .wdata(cmd_data), .raddr(cmd_addr), .rdata(mem_q)
  );

  assign rd_load = (act == ACT_READ) && (!rd_valid || rd_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (act == ACT_WEN_SET) wen <= 1'b1;
      else if (act == ACT_WEN_CLR) wen <= 1'b0;
      if (rd_load) begin
        rd_valid <= 1'b1;
        rd_data  <= mem_q;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mw_guard_chk.sv
module mw_guard_chk #(
  parameter int DEPTH = 512,
  parameter int DW    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs,
  input logic                  mem_we,
  input logic                  wen,
  input logic                  active,
  input logic [$clog2($clog2(DEPTH)+DW+5):0] fr_cnt,
  input logic                  rd_valid,
  input logic                  rd_ready,
  input logic [DW-1:0]         rd_data
);
  localparam int AW        = $clog2(DEPTH);
  localparam int LEN_SHORT = 3 + AW;
  localparam int LEN_LONG  = 3 + AW + DW;

  // R5: a commit follows directly on the first cycle cs is seen low
  a_r5_commit_timing: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!$past(cs) && $past(cs, 2)));

  // R4: memory changes only for an exact legal frame length
  a_r4_exact_len: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (int'(fr_cnt) == LEN_SHORT || int'(fr_cnt) == LEN_LONG));

  // R6: no change without the write-enable latch
  a_r6_wen_gate: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wen);

  // R9: a waiting read byte holds until accepted
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R2: a deselected device drops any partial frame
  a_r2_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !active);
endmodule

bind mw_guard_top mw_guard_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .mem_we(mem_we), .wen(wen),
  .active(rx_active), .fr_cnt(fr_cnt), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/sim_mw_guard_top.sv
module sim_mw_guard_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, sclk = 1'b0, sdi = 1'b0, rd_ready = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  int         vectors = 0, miscompares = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  mw_guard_top u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    sdi = b; tick(2); sclk = 1'b1; tick(2); sclk = 1'b0;
  endtask

  task automatic send(input logic [127:0] bits, input int n);
    cs = 1'b1; tick(2);
    for (int i = n - 1; i >= 0; i--) clk_bit(bits[i]);
    tick(2); cs = 1'b0; tick(4);
  endtask

  function automatic logic [127:0] f_write(input logic [8:0] a, input logic [7:0] d);
    return {108'b0, 3'b101, a, d};
  endfunction
  function automatic logic [127:0] f_short(input logic [1:0] op, input logic [8:0] a);
    return {116'b0, 1'b1, op, a};
  endfunction

  task automatic wen_set(); send(f_short(2'b00, 9'h180), 12); endtask
  task automatic wen_clr(); send(f_short(2'b00, 9'h000), 12); endtask

  task automatic read_chk(input string req, input logic [8:0] a, input logic [7:0] exp);
    send(f_short(2'b10, a), 12);
    for (int i = 0; i < 20 && !rd_valid; i++) tick(1);
    check(req, rd_valid, 1);
    check(req, rd_data, exp);
    rd_ready = 1'b1; tick(1); rd_ready = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    check("R1 rd_valid", rd_valid, 0);
    read_chk("R1 cleared byte", 9'h005, 8'h00);
    send(f_write(9'h005, 8'hAB), 20);          // latch still clear
    read_chk("R1 wen clear", 9'h005, 8'h00);
  endtask

  task automatic t_write();
    wen_set();
    send(f_write(9'h1A5, 8'h3C), 20);          // R3, applied per R5 right after cs fall
    read_chk("R3 write", 9'h1A5, 8'h3C);
    send(f_write(9'h0C3, 8'h96), 20);
    read_chk("R3 write pattern 2", 9'h0C3, 8'h96);
  endtask

  task automatic t_start_bit();
    for (int i = 0; i < 5; i++) begin          // pulses while deselected
      sdi = 1'b1; tick(2); sclk = 1'b1; tick(2); sclk = 1'b0; tick(1);
    end
    send({105'b0, 3'b000, f_write(9'h044, 8'h5E)[19:0]}, 23); // leading zeros
    read_chk("R2 leading zeros", 9'h044, 8'h5E);
  endtask

  task automatic t_glitch();
    logic [8:0] a = 9'h1A5;
    send({107'b0, 3'b101, a[8], a, 8'hFF}, 21);  // one extra pulse
    read_chk("R4 extra pulse", 9'h1A5, 8'h3C);
    read_chk("R4 shifted target", 9'h0D2, 8'h00);
    send(f_write(9'h1A5, 8'h00) >> 1, 19);       // one pulse short
    read_chk("R4 missing pulse", 9'h1A5, 8'h3C);
  endtask

  task automatic t_erase();
    send(f_short(2'b11, 9'h1A5), 12);
    read_chk("R7 erase", 9'h1A5, 8'hFF);
    send(f_write(9'h010, 8'h11), 20);
    send({f_short(2'b11, 9'h010), 1'b0}, 13);
    read_chk("R7 long erase", 9'h010, 8'h11);
  endtask

  task automatic t_fill();
    send({108'b0, 3'b100, 2'b01, 7'b0, 8'h77}, 20);
    read_chk("R8 fill write low", 9'h000, 8'h77);
    read_chk("R8 fill write high", 9'h1FF, 8'h77);
    send(f_short(2'b00, 9'h100), 12);
    read_chk("R8 fill erase", 9'h0AA, 8'hFF);
    wen_clr();
    send(f_write(9'h0AA, 8'h12), 20);
    send(f_short(2'b11, 9'h0AB), 12);
    read_chk("R6 write disabled", 9'h0AA, 8'hFF);
    wen_set();
    send(f_write(9'h0AB, 8'h34), 20);
    read_chk("R6 re-enabled", 9'h0AB, 8'h34);
  endtask

  task automatic t_read_hold();
    send(f_write(9'h020, 8'hC1), 20);
    send(f_write(9'h021, 8'hD2), 20);
    send(f_short(2'b10, 9'h020), 12);
    tick(10);
    check("R9 held valid", rd_valid, 1);
    check("R9 held data", rd_data, 8'hC1);
    send(f_short(2'b10, 9'h021), 12);          // dropped while pending
    check("R9 pending kept", rd_data, 8'hC1);
    rd_ready = 1'b1; tick(1); rd_ready = 1'b0; tick(1);
    check("R9 accepted", rd_valid, 0);
  endtask

  task automatic t_saturate();
    send(f_write(9'h000, 8'h5A), 20);
    send({f_write(9'h000, 8'h5A)[19:0], 64'b0}, 84);
    read_chk("R10 no wrap", 9'h000, 8'h5A);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(2);
    t_reset();
    t_write();
    t_start_bit();
    t_glitch();
    t_erase();
    t_fill();
    t_read_hold();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++; miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule